// File: doc/BRIEF.md
# Flash Converter Output Encoder

This block is the digital back end of a 6-bit parallel (flash) analog-to-digital converter. Each clock it receives 63 comparator decisions, which normally form a thermometer code, plus one more comparator that fires when the analog input is above full scale. It latches those decisions, removes isolated bubbles with a three-input majority vote, turns the result into a 6-bit binary word and an over-range flag, and presents both from an output register. One new result comes out every clock.

Every clock period has a sample half and an auto-balance half. A phase-select input picks which clock level is the sample half. Comparator decisions are captured when the sample half ends, and the matching result appears on the outputs one and a half clock periods later. Two output-enable flags stand in for three-state drivers. The data word is enabled only when both bus enables agree. The over-range flag needs only the active-high enable, so two converters can share one bus and be stacked for one more bit of resolution.

Top module: `flash_backend`

## Requirements
- R1: With `phase_sel` = 0 the low clock level is the sample half and comparators are captured on the rising clock edge. With `phase_sel` = 1 the high level is the sample half and capture is on the falling edge. `phase_sel` changes only while reset is asserted.
- R2: The result of a capture appears on `code` and `over` exactly 1.5 clock periods after the capture edge, and a new capture is taken every clock period.
- R3: Bit i of `comp_therm` is comparator i, counted from the lowest threshold. Without over-range, `code` is one plus the index of the highest set comparator after correction, or 0 when none is set. An all-zero input gives `code` = 0 and `over` = 0.
- R4: Before encoding, each comparator is replaced by the majority of itself and its two neighbours. The neighbour below comparator 0 counts as 1 and the neighbour above comparator 62 is `comp_over`.
- R5: When `comp_over` is captured as 1, `over` is 1 and `code` is 63 (all ones), whatever the other comparators show.
- R6: `code_oe` is 1 only when `bus_en_n` = 0 and `bus_en` = 1, and is 0 for the other three combinations.
- R7: `over_oe` follows `bus_en` alone. `bus_en_n` has no effect on it.
- R8: Reset (`rst_n` = 0) clears `code` and `over` to 0 at once, without waiting for a clock. Its release takes effect after two sample-ending edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_sel | input | 1 | Chooses which clock level is the sample half |
| comp_therm | input | 63 | Comparator decisions, bit 0 = lowest threshold |
| comp_over | input | 1 | Above-full-scale comparator |
| bus_en_n | input | 1 | Active-low data enable |
| bus_en | input | 1 | Active-high enable for data and over-range flag |
| code | output | 6 | Registered binary result |
| over | output | 1 | Registered over-range flag |
| code_oe | output | 1 | Data word drive enable |
| over_oe | output | 1 | Over-range flag drive enable |

## Verification
A comparator vector captured at a sample-ending edge must show up on `code` and `over` one and a half periods later, which is the second drive point after the one where it was applied. The bench applies each vector half a period before its capture edge and samples the outputs 1 ns after each later drive point, so the output register has settled and nothing changes near the check. A result that comes half a period early or late therefore fails at once. The enable flags are combinational, so they are checked 0.5 ns after the enables change. The asynchronous clear is checked 0.2 ns after reset falls, before any clock edge can occur.

// File: rtl/flash_pkg.sv
package flash_pkg;

  // Internal conversion half: sample while comparators track, balance while they settle.
  typedef enum logic {
    PH_SAMPLE  = 1'b0,
    PH_BALANCE = 1'b1
  } conv_phase_e;

  // Three-input majority used by the bubble filter.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/flash_bubble_fix.sv
module flash_bubble_fix #(
  parameter int unsigned N_CMP = 63
) (
  input  logic [N_CMP-1:0] therm_i,
  input  logic             over_i,
  output logic [N_CMP-1:0] therm_o
);
  import flash_pkg::*;

  // Extended vector: a forced 1 below the lowest comparator, the over-range comparator on top.
  logic [N_CMP+1:0] ext;
  assign ext = {over_i, therm_i, 1'b1};

  for (genvar i = 0; i < N_CMP; i++) begin : g_vote
    assign therm_o[i] = maj3(ext[i], ext[i+1], ext[i+2]);
  end

endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned N_CMP  = (1 << CODE_W) - 1
) (
  input  logic [N_CMP-1:0]  therm_i,
  input  logic              over_i,
  output logic [CODE_W-1:0] code_o,
  output logic              over_o
);

  logic [CODE_W-1:0] top_idx;

  // Highest set comparator wins; a later (higher) hit overrides a lower one.
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < int'(N_CMP); i++) begin
      if (therm_i[i]) begin
        top_idx = CODE_W'(i + 1);
      end
    end
  end

  always_comb begin
    over_o = over_i;
    code_o = over_i ? {CODE_W{1'b1}} : top_idx;
  end

endmodule

// File: rtl/flash_backend.sv
module flash_backend #(
  parameter int unsigned CODE_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         phase_sel,
  input  logic [(1 << CODE_W) - 2 : 0] comp_therm,
  input  logic                         comp_over,
  input  logic                         bus_en_n,
  input  logic                         bus_en,
  output logic [CODE_W-1:0]            code,
  output logic                         over,
  output logic                         code_oe,
  output logic                         over_oe
);
  import flash_pkg::*;

  localparam int unsigned N_CMP = (1 << CODE_W) - 1;

  // Internal phase: clock level XOR phase select. Its rising edge ends the sample half.
  conv_phase_e cur_phase;
  logic        samp_clk;
  logic        rst_int_n;

  assign cur_phase = conv_phase_e'(clk ^ phase_sel);
  assign samp_clk  = (cur_phase == PH_BALANCE);

  flash_rst_sync #(.STAGES(2)) u_rst (
    .clk    (samp_clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  // Stage 1: comparator latch, loaded at the end of every sample half.
  logic [N_CMP-1:0] cap_therm_q, cap_therm_d;
  logic             cap_over_q,  cap_over_d;
  logic             cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    cap_therm_d = cap_therm_q;
    cap_over_d  = cap_over_q;
    if (cap_en) begin
      cap_therm_d = comp_therm;
      cap_over_d  = comp_over;
    end
  end

  always_ff @(posedge samp_clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_therm_q <= '0;
      cap_over_q  <= 1'b0;
    end else begin
      cap_therm_q <= cap_therm_d;
      cap_over_q  <= cap_over_d;
    end
  end

  // Bubble filter and encoder between stage 1 and stage 2.
  logic [N_CMP-1:0]  fixed_therm;
  logic [CODE_W-1:0] enc_code;
  logic              enc_over;

  flash_bubble_fix #(.N_CMP(N_CMP)) u_fix (
    .therm_i (cap_therm_q),
    .over_i  (cap_over_q),
    .therm_o (fixed_therm)
  );

  flash_therm_enc #(.CODE_W(CODE_W), .N_CMP(N_CMP)) u_enc (
    .therm_i (fixed_therm),
    .over_i  (cap_over_q),
    .code_o  (enc_code),
    .over_o  (enc_over)
  );

  // Stage 2: encoded word held for one full period.
  logic [CODE_W-1:0] mid_code_q, mid_code_d;
  logic              mid_over_q, mid_over_d;

  always_comb begin
    mid_code_d = enc_code;
    mid_over_d = enc_over;
  end

  always_ff @(posedge samp_clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mid_code_q <= '0;
      mid_over_q <= 1'b0;
    end else begin
      mid_code_q <= mid_code_d;
      mid_over_q <= mid_over_d;
    end
  end

  // Stage 3: output register on the opposite edge, giving the half-period offset.
  logic [CODE_W-1:0] out_code_q, out_code_d;
  logic              out_over_q, out_over_d;

  always_comb begin
    out_code_d = mid_code_q;
    out_over_d = mid_over_q;
  end

  always_ff @(negedge samp_clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_code_q <= '0;
      out_over_q <= 1'b0;
    end else begin
      out_code_q <= out_code_d;
      out_over_q <= out_over_d;
    end
  end

  assign code = out_code_q;
  assign over = out_over_q;

  // Drive enables: data needs both enables, the flag only the active-high one.
  always_comb begin
    code_oe = ~bus_en_n & bus_en;
    over_oe = bus_en;
  end

endmodule

// File: rtl/flash_backend_chk.sv
module flash_backend_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              samp_clk,
  input logic              rst_int_n,
  input logic              comp_over,
  input logic              bus_en_n,
  input logic              bus_en,
  input logic [CODE_W-1:0] code,
  input logic              over,
  input logic              code_oe,
  input logic              over_oe
);

  // Checker's own delay line for the over-range comparator.
  logic ovr_d1, ovr_d2;

  always_ff @(posedge samp_clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovr_d1 <= 1'b0;
      ovr_d2 <= 1'b0;
    end else begin
      ovr_d1 <= comp_over;
      ovr_d2 <= ovr_d1;
    end
  end

  // R2: the flag captured two sample edges ago is on the output now.
  a_r2_over_latency: assert property (@(posedge samp_clk) disable iff (!rst_int_n)
    over == ovr_d2);

  // R5: over-range forces the all-ones word.
  a_r5_saturate: assert property (@(posedge samp_clk) disable iff (!rst_int_n)
    over |-> (code == {CODE_W{1'b1}}));

  // R6: any disagreeing enable keeps the data word undriven.
  a_r6_code_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en_n || !bus_en) |-> !code_oe);

  // R7: the flag stays driven while the data word is off through the active-low enable.
  a_r7_over_keeps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en_n && bus_en) |-> over_oe);

  // R6: data driven implies flag driven.
  a_r6_oe_order: assert property (@(posedge clk) disable iff (!rst_int_n)
    code_oe |-> over_oe);

endmodule

bind flash_backend flash_backend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .samp_clk  (samp_clk),
  .rst_int_n (rst_int_n),
  .comp_over (comp_over),
  .bus_en_n  (bus_en_n),
  .bus_en    (bus_en),
  .code      (code),
  .over      (over),
  .code_oe   (code_oe),
  .over_oe   (over_oe)
);

// File: tb/sim_flash_backend.sv
`timescale 1ns/1ps
module sim_flash_backend;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        phase_sel = 1'b0;
  logic [62:0] comp_therm = '0;
  logic        comp_over = 1'b0;
  logic        bus_en_n = 1'b1;
  logic        bus_en = 1'b0;
  logic [5:0]  code;
  logic        over;
  logic        code_oe;
  logic        over_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [6:0] exp1, exp2;   // {over, code} expected one and two drive points ahead

  always #2.5 clk = ~clk;   // 200 MHz

  flash_backend u0 (
    .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel),
    .comp_therm(comp_therm), .comp_over(comp_over),
    .bus_en_n(bus_en_n), .bus_en(bus_en),
    .code(code), .over(over), .code_oe(code_oe), .over_oe(over_oe)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Reference from the requirements: majority filter with forced 1 below and the
  // over-range comparator above, highest survivor plus one, saturation on over-range.
  function automatic logic [6:0] ref_out(input logic [62:0] t, input logic ov);
    logic [64:0] e;
    int top;
    logic m;
    e = {ov, t, 1'b1};
    top = 0;
    for (int i = 62; i >= 0; i--) begin
      m = (e[i] & e[i+1]) | (e[i] & e[i+2]) | (e[i+1] & e[i+2]);
      if (m && top == 0) top = i + 1;
    end
    if (ov) return 7'h7F;
    return {1'b0, 6'(top)};
  endfunction

  function automatic logic [62:0] therm_of(input int level);
    logic [63:0] w;
    w = (64'h1 << level) - 64'h1;
    return w[62:0];
  endfunction

  // Drive point: half a period before the capture edge (R1).
  task automatic drive_point();
    if (phase_sel == 1'b0) @(negedge clk);
    else                   @(posedge clk);
    #1;
  endtask

  // One step: check the result due now, then apply the next vector and enables.
  task automatic step(input logic [62:0] t, input logic ov);
    logic en_n_v, en_v;
    drive_point();
    chk("R2/R3/R4 code", int'(code), int'(exp2[5:0]));
    chk("R2/R5 over", int'(over), int'(exp2[6]));
    exp2 = exp1;
    exp1 = ref_out(t, ov);
    comp_therm = t;
    comp_over  = ov;
    en_n_v = 1'($urandom);
    en_v   = 1'($urandom);
    bus_en_n = en_n_v;
    bus_en   = en_v;
    #0.5;
    chk("R6 code_oe", int'(code_oe), int'(!en_n_v && en_v));
    chk("R7 over_oe", int'(over_oe), int'(en_v));
  endtask

  task automatic do_reset(input logic ph);
    #0.5;
    rst_n = 1'b0;
    #0.2;
    chk("R8 async clear code", int'(code), 0);
    chk("R8 async clear over", int'(over), 0);
    #1;
    phase_sel = ph;
    comp_therm = '0;
    comp_over  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset code", int'(code), 0);
    chk("R8 reset over", int'(over), 0);
    drive_point();
    rst_n = 1'b1;
    exp1 = '0;
    exp2 = '0;
    for (int i = 0; i < 4; i++) step('0, 1'b0);
  endtask

  task automatic run_phase(input logic ph);
    logic [62:0] t;
    logic ov;
    int lvl;
    do_reset(ph);
    // Directed corners (R3, R4, R5)
    step('0, 1'b0);                          // all zero -> 0
    step(therm_of(63), 1'b0);                // all comparators -> 63, no over
    step(therm_of(63), 1'b1);                // over-range -> 63, over
    step(therm_of(32) & ~(63'h1 << 20), 1'b0); // hole inside the run -> 32
    step(therm_of(10) | (63'h1 << 40), 1'b0);  // stray high comparator -> 10
    step(63'h2, 1'b0);                       // lone 1 at bit 1 -> 1
    step(therm_of(5), 1'b1);                 // over with low run -> saturates
    step(therm_of(62), 1'b0);                // top comparator clear -> 62
    // Random thermometer codes with occasional bubbles
    for (int k = 0; k < 300; k++) begin
      lvl = int'($urandom_range(0, 63));
      t = therm_of(lvl);
      if ($urandom_range(0, 3) == 0) t[$urandom_range(0, 62)] ^= 1'b1;
      ov = (lvl == 63) ? 1'($urandom) : ($urandom_range(0, 15) == 0);
      step(t, ov);
    end
    // Flush so that the last vectors are checked
    step(therm_of(63), 1'b1);
    step('0, 1'b0);
    step('0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    run_phase(1'b0);   // R1: capture on rising edge
    run_phase(1'b1);   // R1: capture on falling edge
    // Async clear while a nonzero result is showing (R8)
    step(therm_of(63), 1'b1);
    step('0, 1'b0);
    step('0, 1'b0);
    chk("R8 pre-reset code", int'(code), 63);
    #0.5;
    rst_n = 1'b0;
    #0.2;
    chk("R8 async clear mid-run code", int'(code), 0);
    chk("R8 async clear mid-run over", int'(over), 0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule